// File: doc/BRIEF.md
# Pipelined Q15 Complex Multiplier with Rounded Output

This block forms the product of two complex numbers. Each number arrives as one 32-bit word that holds two signed Q15 halves. Each cycle the block can accept one operand pair, marked by a valid strobe. A format bit is captured together with the operands and selects one of two results from the same datapath.

In full-precision format the block returns a 32-bit real part and a 32-bit imaginary part, both in Q31. In rounded format it rounds each of those parts to nearest, clamps it, and packs the two 16-bit halves into one 32-bit word. Results leave a two-stage pipeline with a matching valid strobe, and the output holds its last value between valid results.

Top module: `cmul_round_top`

## Requirements
- R1: Each operand word carries its real part in bits 31:16 and its imaginary part in bits 15:0, both as signed two's complement Q15 values.
- R2: In full format (format bit 0), result[63:32] equals the real part 2*(ar*br - ai*bi), clamped to the signed 32-bit range.
- R3: In full format, result[31:0] equals the imaginary part 2*(ar*bi + ai*br), clamped to the signed 32-bit range.
- R4: A full-format part that falls outside the signed 32-bit range clamps to 0x7FFFFFFF or 0x80000000 and does not wrap. For example, real -1.0 times real -1.0 gives a real part of 0x7FFFFFFF.
- R5: In rounded format (format bit 1), result[31:16] holds bits 31:16 of the clamped value (2*(ar*br - ai*bi) + 0x8000), result[15:0] holds the same for the imaginary part, and result[63:32] is zero.
- R6: The rounding offset never causes a wrap. A part whose rounded sum exceeds the 32-bit range gives a packed half of 0x7FFF, and a part below the range gives 0x8000.
- R7: Operands accepted with in_valid high on one rising edge produce out_valid high and their result two rising edges later.
- R8: While out_valid is low, result keeps its previous value, and operands presented with in_valid low have no effect on any output.
- R9: The block accepts a new operand pair on every cycle, and the format bit applies to each pair on its own.
- R10: While rst_n is low, and until the first valid result appears, out_valid is 0 and result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Qualifies op_a, op_b and round_mode |
| round_mode | input | 1 | 0 selects the full Q31 pair, 1 selects the rounded packed 16/16 word |
| op_a | input | 32 | First operand: real part in 31:16, imaginary part in 15:0 |
| op_b | input | 32 | Second operand, same packing as op_a |
| out_valid | output | 1 | High for one cycle for each result |
| result | output | 64 | Full: real in 63:32, imaginary in 31:0. Rounded: zero in 63:32, real in 31:16, imaginary in 15:0 |

## Verification
Every result is due exactly two rising edges after its operands are accepted. The bench drives and samples on falling edges. It keeps a two-entry queue of expected results in step with the pipeline and compares the outputs at the second falling edge after the operands were driven. On every falling edge where no result is due, the bench checks that out_valid is low and that result equals the value seen one cycle earlier. This is how idle cycles and operands without in_valid are shown to have no effect.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

  typedef enum logic {
    FMT_FULL  = 1'b0,
    FMT_ROUND = 1'b1
  } fmt_e;

  typedef struct packed {
    logic vld;
    fmt_e fmt;
  } cmul_ctl_t;

endpackage

// File: rtl/cmul_products.sv
module cmul_products #(
  parameter int unsigned HW = 16
) (
  input  logic [2*HW-1:0] op_a,
  input  logic [2*HW-1:0] op_b,
  output logic [8*HW-1:0] prod_flat
);
  localparam int unsigned PW = 2 * HW;

  logic signed [HW-1:0] a_re, a_im, b_re, b_im;

  assign a_re = op_a[2*HW-1:HW];
  assign a_im = op_a[HW-1:0];
  assign b_re = op_b[2*HW-1:HW];
  assign b_im = op_b[HW-1:0];

  // slot 0: a_re*b_re, slot 1: a_im*b_im, slot 2: a_re*b_im, slot 3: a_im*b_re
  for (genvar g = 0; g < 4; g++) begin : g_mul
    logic signed [HW-1:0] x, y;
    logic signed [PW-1:0] p;
    if (g == 0 || g == 2) begin : g_xre
      assign x = a_re;
    end else begin : g_xim
      assign x = a_im;
    end
    if (g == 0 || g == 3) begin : g_yre
      assign y = b_re;
    end else begin : g_yim
      assign y = b_im;
    end
    assign p = x * y;
    assign prod_flat[g*PW +: PW] = p;
  end

endmodule

// File: rtl/cmul_combine.sv
module cmul_combine #(
  parameter int unsigned HW = 16
) (
  input  logic [8*HW-1:0] prod_flat,
  input  logic            rnd,
  output logic [4*HW-1:0] res
);
  localparam int unsigned PW = 2 * HW;
  localparam int unsigned WW = 2 * HW;
  localparam int unsigned SW = 2 * HW + 2;

  function automatic logic [WW-1:0] clamp(input logic signed [SW-1:0] v);
    logic [WW-1:0] r;
    if (v[SW-1] && !(&v[SW-2:WW-1])) begin
      r = {1'b1, {(WW-1){1'b0}}};
    end else if (!v[SW-1] && (|v[SW-2:WW-1])) begin
      r = {1'b0, {(WW-1){1'b1}}};
    end else begin
      r = v[WW-1:0];
    end
    return r;
  endfunction

  logic signed [SW-1:0] pw [4];
  logic signed [SW-1:0] bias, sum_re, sum_im;
  logic [WW-1:0]        sat_re, sat_im;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      pw[i] = SW'($signed(prod_flat[i*PW +: PW]));
    end
    bias   = rnd ? (SW'(1) <<< (HW - 1)) : '0;
    sum_re = ((pw[0] - pw[1]) <<< 1) + bias;
    sum_im = ((pw[2] + pw[3]) <<< 1) + bias;
    sat_re = clamp(sum_re);
    sat_im = clamp(sum_im);
    if (rnd) begin
      res = {{WW{1'b0}}, sat_re[WW-1:HW], sat_im[WW-1:HW]};
    end else begin
      res = {sat_re, sat_im};
    end
  end

endmodule

// File: rtl/cmul_round_top.sv
module cmul_round_top
  import cmul_pkg::*;
#(
  parameter int unsigned HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          round_mode,
  input  logic [31:0]   op_a,
  input  logic [31:0]   op_b,
  output logic          out_valid,
  output logic [63:0]   result
);
  localparam int unsigned OW = 2 * HW;
  localparam int unsigned QW = 8 * HW;
  localparam int unsigned RW = 4 * HW;

  logic [QW-1:0] prod_d, prod_q;
  cmul_ctl_t     ctl_d, ctl_q;
  logic [RW-1:0] comb_res;
  logic [RW-1:0] res_d, res_q;
  logic          ov_d, ov_q;

  cmul_products #(.HW(HW)) u_prod (
    .op_a      (op_a[OW-1:0]),
    .op_b      (op_b[OW-1:0]),
    .prod_flat (prod_d)
  );

  cmul_combine #(.HW(HW)) u_comb (
    .prod_flat (prod_q),
    .rnd       (ctl_q.fmt == FMT_ROUND),
    .res       (comb_res)
  );

  always_comb begin
    ctl_d.vld = in_valid;
    ctl_d.fmt = fmt_e'(round_mode);
    ov_d      = ctl_q.vld;
    res_d     = comb_res;
  end

  // stage 1: products, loaded only for accepted operands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      ctl_q  <= '0;
    end else begin
      ctl_q.vld <= ctl_d.vld;
      if (in_valid) begin
        prod_q    <= prod_d;
        ctl_q.fmt <= ctl_d.fmt;
      end
    end
  end

  // stage 2: result register, enabled by stage-1 valid
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ov_q  <= 1'b0;
    end else begin
      ov_q <= ov_d;
      if (ctl_q.vld) begin
        res_q <= res_d;
      end
    end
  end

  assign out_valid = ov_q;
  assign result    = 64'(res_q);

endmodule

// File: rtl/cmul_round_chk.sv
module cmul_round_chk #(
  parameter int unsigned HW = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        round_mode,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic        out_valid,
  input logic [63:0] result
);
  localparam logic [31:0] MOST_NEG = 32'(1) << (2*HW - 1);
  localparam logic [31:0] POS_MAX  = (32'(1) << (2*HW - 1)) - 32'd1;

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= 2'd0;
    end else if (since_rst != 2'd3) begin
      since_rst <= since_rst + 2'd1;
    end
  end

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst >= 2'd1) && !out_valid) |-> $stable(result));

  p_round_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst >= 2'd2) && out_valid && $past(round_mode, 2)) |-> (result[63:32] == 32'd0));

  p_clamp_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst >= 2'd2) && out_valid && !$past(round_mode, 2) &&
     ($past(op_a, 2) == MOST_NEG) && ($past(op_b, 2) == MOST_NEG))
    |-> (result[63:32] == POS_MAX));

  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_r10: assert (!out_valid && (result == 64'd0));
    end
  end

endmodule

bind cmul_round_top cmul_round_chk #(.HW(HW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .round_mode (round_mode),
  .op_a       (op_a),
  .op_b       (op_b),
  .out_valid  (out_valid),
  .result     (result)
);

// File: tb/test_cmul_round_top.sv
module test_cmul_round_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        round_mode;
  logic [31:0] op_a, op_b;
  logic        out_valid;
  logic [63:0] result;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  logic        exp_v [2];
  logic [63:0] exp_d [2];
  string       exp_t [2];
  logic [63:0] prev_res;

  cmul_round_top i_cmul_round_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .round_mode (round_mode),
    .op_a       (op_a),
    .op_b       (op_b),
    .out_valid  (out_valid),
    .result     (result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected at most %0d", cycles, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] sat32(longint v);
    if (v > 64'sd2147483647)  return 32'h7FFF_FFFF;
    if (v < -64'sd2147483648) return 32'h8000_0000;
    return v[31:0];
  endfunction

  // R1 packing, R2/R3 full parts, R4 clamping, R5/R6 rounded format
  function automatic logic [63:0] model(logic [31:0] a, logic [31:0] b, logic rnd);
    longint ar = longint'($signed(a[31:16]));
    longint ai = longint'($signed(a[15:0]));
    longint br = longint'($signed(b[31:16]));
    longint bi = longint'($signed(b[15:0]));
    longint re = 2 * (ar * br - ai * bi);
    longint im = 2 * (ar * bi + ai * br);
    logic [31:0] sr, si;
    if (rnd) begin
      re += 32768;
      im += 32768;
    end
    sr = sat32(re);
    si = sat32(im);
    if (rnd) return {32'd0, sr[31:16], si[31:16]};
    return {sr, si};
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // one cycle: check what is due now, advance the model, drive new inputs
  task automatic step(logic v, logic rnd, logic [31:0] a, logic [31:0] b, string tag);
    @(negedge clk);
    if (exp_v[1]) begin
      check(out_valid === 1'b1, {exp_t[1], " R7 valid"}, 64'(out_valid), 64'd1);
      check(result === exp_d[1], exp_t[1], result, exp_d[1]);
    end else begin
      check(out_valid === 1'b0 && result === prev_res, "R8 hold", result, prev_res);
    end
    prev_res = result;
    exp_v[1] = exp_v[0];
    exp_d[1] = exp_d[0];
    exp_t[1] = exp_t[0];
    exp_v[0] = v;
    exp_d[0] = model(a, b, rnd);
    exp_t[0] = tag;
    in_valid   = v;
    round_mode = rnd;
    op_a       = a;
    op_b       = b;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    in_valid = 1'b0;
    round_mode = 1'b0;
    op_a = 32'd0;
    op_b = 32'd0;
    exp_v[0] = 1'b0;
    exp_v[1] = 1'b0;
    exp_d[0] = '0;
    exp_d[1] = '0;
    exp_t[0] = "";
    exp_t[1] = "";
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && result === 64'd0, "R10 in reset", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && result === 64'd0, "R10 after release", result, 64'd0);
    prev_res = result;

    // directed corner cases
    step(1'b1, 1'b0, 32'h4000_0000, 32'h4000_0000, "R2 half*half");
    step(1'b1, 1'b0, 32'h0000_4000, 32'h0000_4000, "R2 i*i");
    step(1'b1, 1'b0, 32'h2000_1000, 32'hF000_3000, "R3 mixed");
    step(1'b1, 1'b0, 32'h8000_0000, 32'h8000_0000, "R4 clamp high");
    step(1'b1, 1'b0, 32'h8000_8000, 32'h7FFF_8000, "R4 clamp low");
    step(1'b1, 1'b1, 32'h8000_0000, 32'h8000_0000, "R6 rounded clamp high");
    step(1'b1, 1'b1, 32'h8000_8000, 32'h7FFF_8000, "R6 rounded clamp low");
    step(1'b1, 1'b1, 32'h7FFF_0000, 32'h7FFF_0000, "R5 rounded");
    step(1'b1, 1'b1, 32'h0001_FFFF, 32'h0001_0001, "R5 small round");
    step(1'b1, 1'b0, 32'hFFFF_0001, 32'h0002_FFFE, "R1 signs");
    step(1'b0, 1'b1, 32'h8000_0000, 32'h8000_0000, "R8 ignored");
    step(1'b0, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0, "R8 ignored");
    step(1'b0, 1'b0, 32'h0, 32'h0, "R8");
    // alternating formats back to back
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 1'(i % 2), 32'h5A5A_A5A5 + 32'(i), 32'h3C3C_C3C3 - 32'(i), "R9 back-to-back");
    end

    // constrained random stream with idle gaps
    for (int i = 0; i < 1500; i++) begin
      logic v, m;
      logic [31:0] a, b;
      v = ($urandom % 4) != 0;
      m = 1'($urandom % 2);
      a = $urandom;
      b = $urandom;
      if ($urandom % 8 == 0) a[31:16] = 16'h8000;
      if ($urandom % 8 == 0) b[15:0]  = 16'h8000;
      step(v, m, a, b, m ? "R5 random" : "R2 R3 random");
    end
    step(1'b0, 1'b0, 32'h0, 32'h0, "R8");
    step(1'b0, 1'b0, 32'h0, 32'h0, "R8");
    step(1'b0, 1'b0, 32'h0, 32'h0, "R8");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule